// File: doc/BRIEF.md
# Standby-Retained Routing Matrix Controller

This block owns the control word of a full audio crossbar that connects stereo source pairs to stereo sink pairs, and decodes that word into one-hot select lines for every sink channel. A host writes registers through a simple write port: an enable, an address and a data word. The port stands in for a serial control bus. The block has one other configuration register besides the routing word. It also keeps an internal flag that records whether any write has been accepted since the last core reset.

There are two reset sources. A power-on reset clears everything, and the routing word becomes all-mute. An active-low standby input holds the core in reset while the supplies are down. When standby ends, a programmable counter delays the release of the core. The routing word is never touched by a standby cycle, so the crossbar keeps routing while the rest of the chip sleeps. The default routing is applied late: it is loaded by the first accepted write after a core reset, unless that write goes to the routing word itself, in which case the written value is used.

Top module: `route_keep_ctrl`

## Requirements
- R1: The routing word holds one 3-bit field per sink channel: left of sink pair 0 at bits [2:0] and right at bits [5:3]. Field code k, for k below 4, selects source channel k, where k = 2*pair + side and side is 0 for left and 1 for right. Channel c of `sel_o` takes bits [4c+3:4c], and code k sets bit k of that slice. An accepted write to address 0 loads the word from `wr_data[5:0]`, and the new selection shows on `sel_o` after the next clock edge.
- R2: Field codes 4 to 7 mute the channel, and its 4-bit slice of `sel_o` is all zero. At most one bit per channel slice is ever set.
- R3: While `por_n` is low, the routing word is forced to all-mute (`sel_o` = 0), `ready_o` is low and `cfg_o` returns to 8'hA5.
- R4: While `stby_n` is low, `ready_o` is low and writes are ignored. The routing word and `sel_o` hold their value.
- R5: Once `por_n` and `stby_n` are both high, `ready_o` rises on the (D+1)-th clock edge, where D is `dly_cycles`. It stays low after the D-th edge.
- R6: Every core reset, including standby exit, returns the configuration register to 8'hA5 while the routing word keeps its value.
- R7: The first accepted write after a core reset that is not to address 0 loads the default routing: sink pair o takes source pair o mod 2, which gives `sel_o` = 8'h21. Later writes to other addresses leave the routing unchanged.
- R8: If the first accepted write after a core reset is to address 0, the written value is kept, and the default is not applied on later writes.
- R9: A write to an unmapped address (any address other than 0 and 1) counts as the first write for R7.
- R10: An accepted write to address 1 loads `cfg_o` from `wr_data[7:0]` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, kept running in standby |
| por_n | input | 1 | Synchronous active-low power-on reset |
| stby_n | input | 1 | Active-low standby request |
| dly_cycles | input | 16 | Reset-release delay in clock cycles after standby or power-on reset ends |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address: 0 routing word, 1 configuration register |
| wr_data | input | 16 | Write data |
| ready_o | output | 1 | Core out of reset, writes accepted |
| cfg_o | output | 8 | Configuration register value |
| sel_o | output | 8 | One-hot crossbar selects, 4 bits per sink channel |

## Verification
The bench goes after the late default. It checks that the first write loads the default route when it goes to the configuration register or to an unmapped address, and not when it goes to the routing word. A design that applied the default at reset would drop the retained route right at standby exit. A design that ignored the first-write rule would either clobber a freshly written route or never apply the default. The bench also attempts writes during standby, which a design with the wrong gating would accept. It probes the release delay one edge early and one edge late, including a zero delay, and drives the mute codes above the source range, where a partial decoder would light a select line.

// File: rtl/rkc_pkg.sv
// Package: shared write-target type and a helper that builds routing words.
// Assumes the code 2*n_in is the mute code and fits in sel_w bits.
package rkc_pkg;

    typedef enum logic [1:0] {
        RK_ROUTE = 2'd0,
        RK_CFG   = 2'd1,
        RK_NONE  = 2'd2
    } rk_target_e;

    // Build a routing word: identity pair mapping, or all channels muted.
    function automatic logic [63:0] rk_route_word(input int n_in, input int n_out,
                                                  input int sel_w, input bit mute);
        logic [63:0] w;
        int          l_code;
        int          r_code;
        w = '0;
        for (int o = 0; o < n_out; o++) begin
            l_code = mute ? 2 * n_in : 2 * (o % n_in);
            r_code = mute ? 2 * n_in : 2 * (o % n_in) + 1;
            w = w | (64'(l_code) << ((2 * o) * sel_w));
            w = w | (64'(r_code) << ((2 * o + 1) * sel_w));
        end
        return w;
    endfunction

endpackage

// File: rtl/rkc_release.sv
// Release-delay counter: holds the core in reset while power-on reset or
// standby is active, then releases it after a programmable number of cycles.
// Assumes dly_cycles stays constant while the counter runs.
module rkc_release #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             stby_n,
    input  logic [DLY_W-1:0] dly_cycles,
    output logic             ready_o
);

    logic [DLY_W-1:0] cnt_q;
    logic             ready_q;

    // Count the release delay and raise ready when it has elapsed.
    always_ff @(posedge clk) begin
        if (!por_n || !stby_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            if (cnt_q == dly_cycles) begin
                ready_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ready_o = ready_q;

endmodule

// File: rtl/rkc_regs.sv
// Register file: the retained routing word (cleared only by power-on reset),
// the configuration register and the first-write flag (cleared by any core
// reset). Applies the default routing on the first accepted write unless
// that write targets the routing word. Assumes ROUTE_W <= DATA_W, CFG_W <= DATA_W.
module rkc_regs
    import rkc_pkg::*;
#(
    parameter int              ADDR_W      = 4,
    parameter int              DATA_W      = 16,
    parameter int              CFG_W       = 8,
    parameter int              ROUTE_W     = 6,
    parameter int              ROUTE_ADDR  = 0,
    parameter int              CFG_ADDR    = 1,
    parameter logic [CFG_W-1:0]   CFG_DEFAULT = 8'hA5,
    parameter logic [ROUTE_W-1:0] ROUTE_DEF   = '0,
    parameter logic [ROUTE_W-1:0] ROUTE_MUTE  = '0
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ready_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [ROUTE_W-1:0] route_o,
    output logic [CFG_W-1:0]   cfg_o
);

    rk_target_e         tgt;
    logic               acc;
    logic               seen_q;
    logic [ROUTE_W-1:0] route_q;
    logic [CFG_W-1:0]   cfg_q;
    logic               unused_data;

    assign unused_data = ^wr_data;
    assign acc         = wr_en && ready_i;

    // Decode the write address into a register target.
    always_comb begin
        if (wr_addr == ADDR_W'(ROUTE_ADDR)) begin
            tgt = RK_ROUTE;
        end else if (wr_addr == ADDR_W'(CFG_ADDR)) begin
            tgt = RK_CFG;
        end else begin
            tgt = RK_NONE;
        end
    end

    // Retained routing word: direct write, or late default on first write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            route_q <= ROUTE_MUTE;
        end else if (acc) begin
            if (tgt == RK_ROUTE) begin
                route_q <= wr_data[ROUTE_W-1:0];
            end else if (!seen_q) begin
                route_q <= ROUTE_DEF;
            end
        end
    end

    // First-write flag: cleared by any core reset, set by any accepted write.
    always_ff @(posedge clk) begin
        if (!por_n || !ready_i) begin
            seen_q <= 1'b0;
        end else if (acc) begin
            seen_q <= 1'b1;
        end
    end

    // Configuration register: back to default on every core reset.
    always_ff @(posedge clk) begin
        if (!por_n || !ready_i) begin
            cfg_q <= CFG_DEFAULT;
        end else if (acc && tgt == RK_CFG) begin
            cfg_q <= wr_data[CFG_W-1:0];
        end
    end

    assign route_o = route_q;
    assign cfg_o   = cfg_q;

endmodule

// File: rtl/rkc_sel_dec.sv
// Select decoder: turns each SEL_W-bit channel field into a one-hot select
// over N_SRC sources. Codes at or above N_SRC give an all-zero (muted) slice.
module rkc_sel_dec #(
    parameter int N_CH  = 2,
    parameter int N_SRC = 4,
    parameter int SEL_W = 3
) (
    input  logic [N_CH*SEL_W-1:0] route_i,
    output logic [N_CH*N_SRC-1:0] sel_o
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [SEL_W-1:0] field;
        assign field = route_i[c*SEL_W +: SEL_W];
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            // One select line per source: active when the field names it.
            assign sel_o[c*N_SRC + s] = (field == SEL_W'(s));
        end
    end

endmodule

// File: rtl/route_keep_ctrl.sv
// Top: standby-retained routing matrix controller. Ties together the
// release-delay counter, the register file and the select decoder.
// Assumes clk keeps running in standby and all resets are synchronous.
module route_keep_ctrl
    import rkc_pkg::*;
#(
    parameter int               N_IN_PAIRS  = 2,
    parameter int               N_OUT_PAIRS = 1,
    parameter int               ADDR_W      = 4,
    parameter int               DATA_W      = 16,
    parameter int               CFG_W       = 8,
    parameter int               DLY_W       = 16,
    parameter int               ROUTE_ADDR  = 0,
    parameter int               CFG_ADDR    = 1,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'hA5,
    localparam int              N_SRC       = 2 * N_IN_PAIRS,
    localparam int              N_CH        = 2 * N_OUT_PAIRS
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  stby_n,
    input  logic [DLY_W-1:0]      dly_cycles,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  ready_o,
    output logic [CFG_W-1:0]      cfg_o,
    output logic [N_CH*N_SRC-1:0] sel_o
);

    localparam int SEL_W   = $clog2(N_SRC + 1);
    localparam int ROUTE_W = N_CH * SEL_W;
    localparam logic [ROUTE_W-1:0] ROUTE_DEF  =
        ROUTE_W'(rk_route_word(N_IN_PAIRS, N_OUT_PAIRS, SEL_W, 1'b0));
    localparam logic [ROUTE_W-1:0] ROUTE_MUTE =
        ROUTE_W'(rk_route_word(N_IN_PAIRS, N_OUT_PAIRS, SEL_W, 1'b1));

    logic               ready;
    logic [ROUTE_W-1:0] route;

    rkc_release #(
        .DLY_W (DLY_W)
    ) release_i (
        .clk        (clk),
        .por_n      (por_n),
        .stby_n     (stby_n),
        .dly_cycles (dly_cycles),
        .ready_o    (ready)
    );

    rkc_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .CFG_W       (CFG_W),
        .ROUTE_W     (ROUTE_W),
        .ROUTE_ADDR  (ROUTE_ADDR),
        .CFG_ADDR    (CFG_ADDR),
        .CFG_DEFAULT (CFG_DEFAULT),
        .ROUTE_DEF   (ROUTE_DEF),
        .ROUTE_MUTE  (ROUTE_MUTE)
    ) regs_i (
        .clk     (clk),
        .por_n   (por_n),
        .ready_i (ready),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .route_o (route),
        .cfg_o   (cfg_o)
    );

    rkc_sel_dec #(
        .N_CH  (N_CH),
        .N_SRC (N_SRC),
        .SEL_W (SEL_W)
    ) dec_i (
        .route_i (route),
        .sel_o   (sel_o)
    );

    assign ready_o = ready;

endmodule

// File: rtl/rkc_checker.sv
// Checker: temporal properties over the top module's ports, bound below.
module rkc_checker #(
    parameter int               N_CH        = 2,
    parameter int               N_SRC       = 4,
    parameter int               CFG_W       = 8,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'hA5
) (
    input logic                  clk,
    input logic                  por_n,
    input logic                  stby_n,
    input logic                  wr_en,
    input logic                  ready_o,
    input logic [CFG_W-1:0]      cfg_o,
    input logic [N_CH*N_SRC-1:0] sel_o
);

    for (genvar c = 0; c < N_CH; c++) begin : g_oh
        AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!por_n)
            $onehot0(sel_o[c*N_SRC +: N_SRC])); // R2
    end

    AST_ROUTE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        !(ready_o && wr_en) |=> $stable(sel_o)); // R1

    AST_STBY_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (!stby_n && !ready_o) |=> $stable(sel_o)); // R4

    AST_READY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ready_o) |-> ($past(por_n) && $past(stby_n))); // R5

    AST_CFG_DEFAULT_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        !ready_o |=> (cfg_o == CFG_DEFAULT)); // R6

endmodule

bind route_keep_ctrl rkc_checker #(
    .N_CH        (N_CH),
    .N_SRC       (N_SRC),
    .CFG_W       (CFG_W),
    .CFG_DEFAULT (CFG_DEFAULT)
) chk_i (
    .clk     (clk),
    .por_n   (por_n),
    .stby_n  (stby_n),
    .wr_en   (wr_en),
    .ready_o (ready_o),
    .cfg_o   (cfg_o),
    .sel_o   (sel_o)
);

// File: tb/route_keep_ctrl_tb_top.sv
module route_keep_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        stby_n = 1'b1;
    logic [15:0] dly_cycles = 16'd3;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ready_o;
    logic [7:0]  cfg_o;
    logic [7:0]  sel_o;

    int checks = 0;
    int errors = 0;

    // {routing data byte, expected sel_o byte}
    localparam logic [15:0] VEC [0:7] = '{
        16'h13_48, 16'h00_11, 16'h09_22, 16'h24_00,
        16'h05_10, 16'h3F_00, 16'h1A_84, 16'h20_01
    };

    always #4 clk = ~clk;

    route_keep_ctrl dut_i (
        .clk(clk), .por_n(por_n), .stby_n(stby_n), .dly_cycles(dly_cycles),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ready_o(ready_o), .cfg_o(cfg_o), .sel_o(sel_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic release_wait(input int d, input string req);
        repeat (d) @(negedge clk);
        chk(req, 16'(ready_o), 16'd0);
        @(negedge clk);
        chk(req, 16'(ready_o), 16'd1);
    endtask

    task automatic standby_cycle(input int d);
        @(negedge clk) stby_n = 1'b0;
        repeat (3) @(negedge clk);
        dly_cycles = 16'(d);
        @(negedge clk) stby_n = 1'b1;
        release_wait(d, "R5");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R3: power-on reset state
        repeat (4) @(negedge clk);
        chk("R3 ready", 16'(ready_o), 16'd0);
        chk("R3 sel", 16'(sel_o), 16'h00);
        chk("R3 cfg", 16'(cfg_o), 16'hA5);
        por_n = 1'b1;
        release_wait(3, "R5");

        // R7/R10: first write to cfg applies default routing
        wr(4'd1, 16'h003C);
        chk("R10 cfg", 16'(cfg_o), 16'h3C);
        chk("R7 default", 16'(sel_o), 16'h21);
        wr(4'd1, 16'h0077);
        chk("R10 cfg2", 16'(cfg_o), 16'h77);
        chk("R7 no reapply", 16'(sel_o), 16'h21);

        // R1/R2: routing vectors
        for (int i = 0; i < 8; i++) begin
            wr(4'd0, {8'h00, VEC[i][15:8]});
            chk("R1 R2 vector", 16'(sel_o), {8'h00, VEC[i][7:0]});
        end
        wr(4'd0, 16'hFF13);
        chk("R1 upper data ignored", 16'(sel_o), 16'h48);

        // R4/R6: standby holds routing, ignores writes, resets cfg
        @(negedge clk) stby_n = 1'b0;
        repeat (2) @(negedge clk);
        wr(4'd0, 16'h0009);
        wr(4'd1, 16'h0011);
        chk("R4 ready", 16'(ready_o), 16'd0);
        chk("R4 sel held", 16'(sel_o), 16'h48);
        chk("R6 cfg default", 16'(cfg_o), 16'hA5);
        @(negedge clk) stby_n = 1'b1;
        release_wait(3, "R5");
        chk("R6 sel retained", 16'(sel_o), 16'h48);
        chk("R6 cfg after exit", 16'(cfg_o), 16'hA5);

        // R9: unmapped first write applies default
        wr(4'd5, 16'h0000);
        chk("R9 unmapped default", 16'(sel_o), 16'h21);
        chk("R9 cfg untouched", 16'(cfg_o), 16'hA5);
        wr(4'd0, 16'h0013);
        wr(4'd1, 16'h0042);
        chk("R7 later cfg write", 16'(sel_o), 16'h48);

        // R8: first write to routing wins over default
        standby_cycle(2);
        wr(4'd0, 16'h001A);
        chk("R8 written kept", 16'(sel_o), 16'h84);
        wr(4'd1, 16'h0001);
        chk("R8 no default", 16'(sel_o), 16'h84);
        wr(4'd7, 16'h0001);
        chk("R8 no default unmapped", 16'(sel_o), 16'h84);

        // R5: zero delay releases on first edge
        standby_cycle(0);
        chk("R6 retained zero delay", 16'(sel_o), 16'h84);

        // R3: power-on reset mid-run mutes routing
        @(negedge clk) por_n = 1'b0;
        @(negedge clk);
        chk("R3 por mute", 16'(sel_o), 16'h00);
        chk("R3 por ready", 16'(ready_o), 16'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule